// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Transceiver with Idle-Line Wakeup

This block is a full-duplex asynchronous serial port. It carries NRZ frames made of one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Both directions are paced by a baud tick that the surrounding logic supplies at sixteen times the bit rate. The block does not divide the clock to make this tick.

The receiver synchronises the line and counts oversampling phases. It decides each data bit by a three-sample majority vote and each start or stop bit by a seven-sample vote. It re-aligns its phase on every falling edge of the line, so a sender whose bit rate is off can still be received. Each accepted character is reported together with framing-error and noise flags. A character that arrives while the previous one is unread is lost and raises an overrun flag. Software can put the receiver into standby. In standby, traffic meant for other nodes is thrown away until the line has been idle for one whole character time.

The transmitter has a one-entry holding register in front of a frame shifter. A write can queue a data character, a whole character of ones (idle) or a whole character of zeros (break). Two status outputs show whether the holding register is free and whether all transmission has finished.

Top module: `sci_link`

## Requirements
- R1: The input `frame9` selects nine data bits when 1 and eight when 0. A frame is a start bit (0), the data bits least significant first, then a stop bit (1). In eight-bit mode `rx_data[8]` reads 0.
- R2: A data bit is the majority of the samples at tick phases 7, 8 and 9 of its 16-tick bit time. Phase 1 is the tick that first sees the falling start edge. A single wrong sample does not change the bit.
- R3: The start and stop bits are each the majority of seven samples, at phases 5 to 11. A start bit whose majority is 1 is a false start: nothing is reported, and the receiver returns to waiting for an edge. A single wrong sample is tolerated.
- R4: On every falling edge inside a frame, the receiver re-aligns. If the edge comes before the current bit's sample window, the bit restarts at phase 1. If it comes after the window, the next bit starts at phase 1. With this, a frame of alternating bits sent at 18 ticks per bit is decoded correctly.
- R5: An accepted character sets `rx_frame_err` when the stop-bit majority is 0. It sets `rx_noise` when any vote in the frame was not unanimous. Both flags always describe the last accepted character.
- R6: A character that completes while `rx_full` is set and `rx_read` is low is dropped. In that case `rx_overrun` sets and `rx_data` keeps its value. A one-cycle `rx_read` pulse clears `rx_full` and `rx_overrun`.
- R7: A `standby_req` pulse sets `rx_standby`. While it is set, completed characters change neither the data nor any flag. Standby clears after 16 × (10 or 11, the frame length) consecutive high line samples.
- R8: `tx_write` queues an entry of kind `tx_kind`: 2'b00 is data, 2'b10 is break (all zeros for the frame length), and 2'b01 or 2'b11 is idle (all ones for the frame length). Each bit lasts 16 ticks.
- R9: `tx_empty` is low while the holding register is occupied. The entry moves to the shifter in the first cycle in which the shifter is free. A write while the holding register is occupied is ignored.
- R10: `tx_done` clears when a write is accepted. It sets when the last bit of a frame ends with the holding register empty. While `tx_done` is set, `txd` is high.
- R11: After reset: `txd`=1, `tx_empty`=1, `tx_done`=1, `rx_full`=0, `rx_standby`=0, `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 × bit rate |
| frame9 | input | 1 | 1 = nine data bits, 0 = eight |
| rxd | input | 1 | Serial receive line |
| rx_read | input | 1 | Consume received character |
| standby_req | input | 1 | Enter receiver standby |
| tx_write | input | 1 | Queue a transmit entry |
| tx_kind | input | 2 | Entry kind: data, idle or break |
| tx_data | input | 9 | Transmit character |
| txd | output | 1 | Serial transmit line |
| rx_data | output | 9 | Last accepted character |
| rx_full | output | 1 | Unread character present |
| rx_overrun | output | 1 | Character lost while full |
| rx_frame_err | output | 1 | Stop bit voted low |
| rx_noise | output | 1 | A vote was not unanimous |
| rx_standby | output | 1 | Receiver in standby |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission finished, line idle |

## Verification
The bench builds the block with the default oversampling factor of 16. This puts the data-bit window at ticks 7 to 9 and the start/stop window at ticks 5 to 11, so a glitch on one chosen tick hits exactly one sample. The baud tick is pulsed every fourth clock, which keeps an eleven-bit frame at about 700 cycles. This makes room for random traffic in both frame lengths, 18-tick stretched frames that only decode if re-alignment works, and the ten-bit-time idle wakeup.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int FRAME_MAX = 11;
  localparam int DATA_W    = 9;

  typedef enum logic [1:0] {
    TXK_DATA  = 2'b00,
    TXK_IDLE  = 2'b01,
    TXK_BREAK = 2'b10
  } txk_e;

  // bit times in one frame
  function automatic logic [3:0] frame_bits(input logic nine);
    return nine ? 4'd11 : 4'd10;
  endfunction

  // line pattern, first bit at index 0
  function automatic logic [FRAME_MAX-1:0] tx_pattern(input logic [1:0] kind, input logic nine,
                                                      input logic [DATA_W-1:0] d);
    logic [FRAME_MAX-1:0] f;
    f = '1;
    if (kind == TXK_BREAK) f = '0;
    else if (kind == TXK_DATA) begin
      f[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) f[i+1] = (i < DATA_W-1 || nine) ? d[i] : 1'b1;
    end
    return f;
  endfunction

  // majority of 3 (narrow) or 7 (wide) samples
  function automatic logic vote(input logic [2:0] ones, input logic wide);
    return wide ? (ones >= 3'd4) : (ones >= 3'd2);
  endfunction

  function automatic logic split(input logic [2:0] ones, input logic wide);
    return (ones != 3'd0) && (ones != (wide ? 3'd7 : 3'd3));
  endfunction
endpackage

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              rxd,
  input  logic              rd,
  input  logic              standby_req,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              overrun,
  output logic              frame_err,
  output logic              noise,
  output logic              standby,
  output logic              take_evt
);
  localparam int PW  = $clog2(OSR + 1);
  localparam int MID = OSR / 2;
  localparam int IW  = $clog2(OSR * FRAME_MAX + 1);

  logic s1, s2, prev;
  logic busy, noisy;
  logic [3:0] bidx, last_idx;
  logic [PW-1:0] ph;
  logic [2:0] ones;
  logic [DATA_W-1:0] shr;
  logic [IW-1:0] icnt, wake_lim;

  function automatic logic [PW-1:0] lo_of(input logic w);
    return w ? PW'(MID - 3) : PW'(MID - 1);
  endfunction
  function automatic logic [PW-1:0] hi_of(input logic w);
    return w ? PW'(MID + 3) : PW'(MID + 1);
  endfunction

  assign last_idx = frame_bits(nine) - 4'd1;
  assign wake_lim = IW'(OSR) * IW'(frame_bits(nine));

  logic fall, newbit, wide, in_win, decide, bitval, bitsplit, frame_end, ovr_evt;
  logic [PW-1:0] nph;
  logic [3:0] nbi;
  logic [2:0] ones_n;

  always_comb begin
    fall   = prev & ~s2;
    newbit = (ph == PW'(OSR));
    nph    = newbit ? PW'(1) : ph + PW'(1);
    nbi    = newbit ? bidx + 4'd1 : bidx;
    wide   = (nbi == 4'd0) || (nbi == last_idx);
    if (fall) begin
      if (nph < lo_of(wide)) nph = PW'(1);
      else if (nph > hi_of(wide) && nbi != last_idx) begin
        nbi    = nbi + 4'd1;
        nph    = PW'(1);
        newbit = 1'b1;
      end
    end
    wide     = (nbi == 4'd0) || (nbi == last_idx);
    in_win   = (nph >= lo_of(wide)) && (nph <= hi_of(wide));
    decide   = (nph == hi_of(wide));
    ones_n   = (newbit ? 3'd0 : ones) + {2'b00, in_win & s2};
    bitval   = vote(ones_n, wide);
    bitsplit = split(ones_n, wide);
  end

  assign frame_end = tick && busy && decide && (nbi == last_idx);
  assign take_evt  = frame_end && !standby && !(full && !rd);
  assign ovr_evt   = frame_end && !standby && full && !rd;

  // line sampling and frame timing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      busy <= 1'b0; bidx <= '0; ph <= '0; ones <= '0; noisy <= 1'b0; shr <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        prev <= s2;
        if (!busy) begin
          if (fall) begin
            busy <= 1'b1; bidx <= '0; ph <= PW'(1); ones <= '0; noisy <= 1'b0; shr <= '0;
          end
        end else begin
          bidx <= nbi;
          ph   <= nph;
          ones <= ones_n;
          if (decide) begin
            noisy <= noisy | bitsplit;
            if (nbi == 4'd0) begin
              if (bitval) busy <= 1'b0;
            end else if (nbi == last_idx) busy <= 1'b0;
            else shr[nbi - 4'd1] <= bitval;
          end
        end
      end
    end
  end

  // character buffer, flags and standby
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0; full <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0; noise <= 1'b0;
      standby <= 1'b0; icnt <= '0;
    end else begin
      if (rd) begin
        full    <= 1'b0;
        overrun <= 1'b0;
      end
      if (ovr_evt) overrun <= 1'b1;
      if (take_evt) begin
        data      <= shr;
        full      <= 1'b1;
        frame_err <= ~bitval;
        noise     <= noisy | bitsplit;
      end
      if (standby_req) begin
        standby <= 1'b1;
        icnt    <= '0;
      end else if (standby && tick) begin
        if (!s2) icnt <= '0;
        else if (icnt == wake_lim - IW'(1)) begin
          standby <= 1'b0;
          icnt    <= '0;
        end else icnt <= icnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/sci_tx.sv
module sci_tx
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              nine,
  input  logic              wr,
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              hold_empty,
  output logic              done,
  output logic              busy
);
  localparam int TW = $clog2(OSR);

  logic hold_full;
  logic [1:0] hold_kind;
  logic [DATA_W-1:0] hold_data;
  logic [FRAME_MAX-1:0] shr;
  logic [3:0] left;
  logic [TW-1:0] tcnt;
  logic accept, move, bit_end, last_end;

  assign accept   = wr && !hold_full;
  assign move     = hold_full && !busy;
  assign bit_end  = busy && tick && (tcnt == TW'(OSR - 1));
  assign last_end = bit_end && (left == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0; hold_kind <= '0; hold_data <= '0;
      busy <= 1'b0; shr <= '1; left <= '0; tcnt <= '0; done <= 1'b1;
    end else begin
      if (move) begin
        shr       <= tx_pattern(hold_kind, nine, hold_data);
        left      <= frame_bits(nine);
        tcnt      <= '0;
        busy      <= 1'b1;
        hold_full <= 1'b0;
      end else if (busy && tick) begin
        if (bit_end) begin
          tcnt <= '0;
          shr  <= {1'b1, shr[FRAME_MAX-1:1]};
          left <= left - 4'd1;
          if (last_end) busy <= 1'b0;
        end else tcnt <= tcnt + TW'(1);
      end
      if (accept) begin
        hold_full <= 1'b1;
        hold_kind <= kind;
        hold_data <= wdata;
        done      <= 1'b0;
      end else if (last_end && !hold_full) done <= 1'b1;
    end
  end

  assign txd        = busy ? shr[0] : 1'b1;
  assign hold_empty = !hold_full;
endmodule

// File: rtl/sci_link.sv
module sci_link
  import sci_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              frame9,
  input  logic              rxd,
  input  logic              rx_read,
  input  logic              standby_req,
  input  logic              tx_write,
  input  logic [1:0]        tx_kind,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rx_frame_err,
  output logic              rx_noise,
  output logic              rx_standby,
  output logic              tx_empty,
  output logic              tx_done
);
  // named internal events for the checker
  logic rx_take;
  logic tx_busy;

  sci_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .nine(frame9), .rxd(rxd),
    .rd(rx_read), .standby_req(standby_req), .data(rx_data), .full(rx_full),
    .overrun(rx_overrun), .frame_err(rx_frame_err), .noise(rx_noise),
    .standby(rx_standby), .take_evt(rx_take)
  );

  sci_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .nine(frame9), .wr(tx_write),
    .kind(tx_kind), .wdata(tx_data), .txd(txd), .hold_empty(tx_empty),
    .done(tx_done), .busy(tx_busy)
  );
endmodule

// File: rtl/sci_link_chk.sv
module sci_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_empty,
  input logic       tx_done,
  input logic       tx_busy,
  input logic       rx_read,
  input logic       rx_standby,
  input logic       rx_full,
  input logic       rx_overrun,
  input logic       rx_noise,
  input logic       rx_take,
  input logic [8:0] rx_data
);
  p_done_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_empty);

  p_done_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);

  p_hold_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !tx_busy) |=> (tx_empty && tx_busy));

  p_overrun_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> (rx_data == $past(rx_data)));

  p_overrun_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_full));

  p_standby_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_standby && !rx_read) |=> ($stable(rx_full) && $stable(rx_data)));

  p_noise_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_noise) |-> $past(rx_take));
endmodule

bind sci_link sci_link_chk u_sci_link_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done),
  .tx_busy(tx_busy), .rx_read(rx_read), .rx_standby(rx_standby), .rx_full(rx_full),
  .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_take(rx_take), .rx_data(rx_data)
);

// File: tb/test_sci_link.sv
`timescale 1ns/1ps
module test_sci_link;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, frame9 = 1'b0, rxd = 1'b1;
  logic rx_read = 1'b0, standby_req = 1'b0, tx_write = 1'b0;
  logic [1:0] tx_kind = 2'b00;
  logic [8:0] tx_data = '0;
  logic txd, rx_full, rx_overrun, rx_frame_err, rx_noise, rx_standby, tx_empty, tx_done;
  logic [8:0] rx_data;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  sci_link i_sci_link (.*);

  always #5 clk = ~clk;

  initial begin : tickgen
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  function automatic logic [8:0] exp_word(input logic nine, input logic [8:0] d);
    return nine ? d : {1'b0, d[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (baud_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic rx_hold(input logic v, input int n);
    rxd = v;
    repeat (n) wait_tick();
  endtask

  // tick k of the bench frame is receiver phase k (1-based per bit)
  task automatic send_rx(input logic nine, input logic [8:0] d, input int tpb,
                         input int gbit, input int gph, input logic stopv);
    int nb;
    nb = nine ? 11 : 10;
    for (int b = 0; b < nb; b++) begin
      logic v;
      if (b == 0) v = 1'b0;
      else if (b == nb - 1) v = stopv;
      else v = d[b-1];
      for (int p = 1; p <= tpb; p++) begin
        rxd = (b == gbit && p == gph) ? ~v : v;
        wait_tick();
      end
    end
    rx_hold(1'b1, 3);
  endtask

  task automatic do_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic tx_put(input logic [1:0] k, input logic [8:0] d);
    @(negedge clk); tx_write = 1'b1; tx_kind = k; tx_data = d;
    @(negedge clk); tx_write = 1'b0;
    @(negedge clk);
  endtask

  // decode one frame on txd, 64 clocks per bit
  task automatic dec_tx(input logic nine, output logic [8:0] d, output logic st,
                        output logic sp, output bit tmo);
    int t;
    t = 0; d = '0;
    while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
    tmo = (t >= 3000);
    repeat (30) @(negedge clk);
    st = txd;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (64) @(negedge clk);
      d[i] = txd;
    end
    repeat (64) @(negedge clk);
    sp = txd;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [8:0] d, got;
    logic st, sp, nine;
    bit tmo;
    int t, lows;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd === 1'b1 && tx_empty === 1'b1 && tx_done === 1'b1, "R11 tx reset", {txd, tx_empty, tx_done}, 7);
    chk(rx_full === 1'b0 && rx_standby === 1'b0 && rx_data === 9'h0, "R11 rx reset", {rx_full, rx_standby}, 0);
    rx_hold(1'b1, 4);

    // R1 R2: random clean frames, both lengths
    for (int n = 0; n < 10; n++) begin
      nine = 1'($urandom % 2);
      frame9 = nine;
      d = 9'($urandom);
      send_rx(nine, d, 16, -1, 0, 1'b1);
      chk(rx_full === 1'b1 && rx_data === exp_word(nine, d), "R1 rx random word", rx_data, exp_word(nine, d));
      chk(rx_noise === 1'b0 && rx_frame_err === 1'b0, "R5 clean flags", {rx_noise, rx_frame_err}, 0);
      do_read();
    end

    frame9 = 1'b0;
    // R2 single bad sample on a data bit
    send_rx(1'b0, 9'h0A6, 16, 3, 8, 1'b1);
    chk(rx_data === 9'h0A6, "R2 data vote survives glitch", rx_data, 9'h0A6);
    chk(rx_noise === 1'b1, "R5 noise on split data vote", rx_noise, 1);
    do_read();
    // R3 one bad sample in start and stop
    send_rx(1'b0, 9'h031, 16, 0, 8, 1'b1);
    chk(rx_full === 1'b1 && rx_data === 9'h031 && rx_noise === 1'b1, "R3 start glitch tolerated", rx_data, 9'h031);
    do_read();
    send_rx(1'b0, 9'h0C2, 16, 9, 6, 1'b1);
    chk(rx_data === 9'h0C2 && rx_frame_err === 1'b0 && rx_noise === 1'b1, "R3 stop glitch tolerated", {rx_frame_err, rx_noise}, 1);
    do_read();
    // R3 false start
    rx_hold(1'b0, 2);
    rx_hold(1'b1, 200);
    chk(rx_full === 1'b0, "R3 false start discarded", rx_full, 0);
    // R5 framing error
    send_rx(1'b0, 9'h05A, 16, -1, 0, 1'b0);
    chk(rx_frame_err === 1'b1 && rx_noise === 1'b0, "R5 framing error", {rx_frame_err, rx_noise}, 2);
    do_read();
    // R4 re-alignment on slow sender
    send_rx(1'b0, 9'h055, 18, -1, 0, 1'b1);
    chk(rx_data === 9'h055 && rx_frame_err === 1'b0, "R4 stretched frame", rx_data, 9'h055);
    do_read();
    frame9 = 1'b1;
    send_rx(1'b1, 9'h155, 18, -1, 0, 1'b1);
    chk(rx_data === 9'h155 && rx_frame_err === 1'b0, "R4 stretched nine-bit frame", rx_data, 9'h155);
    do_read();
    frame9 = 1'b0;

    // R6 overrun
    send_rx(1'b0, 9'h011, 16, -1, 0, 1'b1);
    send_rx(1'b0, 9'h0EE, 16, -1, 0, 1'b1);
    chk(rx_overrun === 1'b1 && rx_full === 1'b1, "R6 overrun set", rx_overrun, 1);
    chk(rx_data === 9'h011, "R6 first char kept", rx_data, 9'h011);
    do_read();
    chk(rx_full === 1'b0 && rx_overrun === 1'b0, "R6 read clears", {rx_full, rx_overrun}, 0);

    // R7 standby and idle-line wakeup
    @(negedge clk); standby_req = 1'b1;
    @(negedge clk); standby_req = 1'b0;
    chk(rx_standby === 1'b1, "R7 standby entered", rx_standby, 1);
    send_rx(1'b0, 9'h000, 16, -1, 0, 1'b1);
    chk(rx_full === 1'b0 && rx_data === 9'h011, "R7 frame ignored in standby", rx_full, 0);
    rx_hold(1'b1, 100);
    chk(rx_standby === 1'b1, "R7 still standby before full idle char", rx_standby, 1);
    rx_hold(1'b1, 60);
    chk(rx_standby === 1'b0, "R7 woke after idle char", rx_standby, 0);
    send_rx(1'b0, 9'h03C, 16, -1, 0, 1'b1);
    chk(rx_full === 1'b1 && rx_data === 9'h03C, "R7 first char after wake", rx_data, 9'h03C);
    do_read();

    // R9 R10 holding register and completion
    tx_put(2'b00, 9'h0A5);
    chk(tx_empty === 1'b1 && tx_done === 1'b0, "R9 moved to shifter", {tx_empty, tx_done}, 2);
    tx_put(2'b00, 9'h03C);
    chk(tx_empty === 1'b0, "R9 second entry held", tx_empty, 0);
    tx_put(2'b00, 9'h0FF);
    dec_tx(1'b0, got, st, sp, tmo);
    chk(!tmo && st === 1'b0 && sp === 1'b1 && got === 9'h0A5, "R8 first frame", got, 9'h0A5);
    chk(tx_done === 1'b0, "R10 not done with entry waiting", tx_done, 0);
    dec_tx(1'b0, got, st, sp, tmo);
    chk(!tmo && sp === 1'b1 && got === 9'h03C, "R8 second frame", got, 9'h03C);
    repeat (64) @(negedge clk);
    chk(tx_done === 1'b1 && tx_empty === 1'b1, "R10 done after last frame", tx_done, 1);
    lows = 0;
    repeat (1500) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk(lows == 0, "R9 write while full ignored", lows, 0);

    // R8 idle then data
    t = 0;
    fork
      begin tx_put(2'b01, 9'h000); tx_put(2'b00, 9'h081); end
      begin while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end end
    join
    chk(t >= 630 && t <= 660, "R8 idle character length", t, 643);
    repeat (30) @(negedge clk);
    got = '0;
    for (int i = 0; i < 8; i++) begin repeat (64) @(negedge clk); got[i] = txd; end
    chk(got === 9'h081, "R8 data after idle", got, 9'h081);
    repeat (200) @(negedge clk);
    // R8 break
    tx_put(2'b10, 9'h1FF);
    lows = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 10; i++) begin if (txd === 1'b0) lows++; repeat (64) @(negedge clk); end
    chk(lows == 10, "R8 break all zeros", lows, 10);
    repeat (80) @(negedge clk);
    chk(txd === 1'b1 && tx_done === 1'b1, "R10 line high after break", txd, 1);

    // R1 nine-bit and random transmit
    for (int n = 0; n < 6; n++) begin
      nine = 1'($urandom % 2);
      frame9 = nine;
      d = 9'($urandom);
      tx_put(2'b00, d);
      dec_tx(nine, got, st, sp, tmo);
      chk(!tmo && st === 1'b0 && sp === 1'b1 && got === exp_word(nine, d), "R1 tx random word", got, exp_word(nine, d));
      repeat (80) @(negedge clk);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule